// File: doc/BRIEF.md
# Bit Shift and Rotate Unit with Condition Flags

This unit performs the single-bit shift and rotate operations of an 8-bit processor datapath. It also provides one 16-bit form that rotates a register pair right through the carry. The operation comes from the second byte of a two-byte opcode. In that byte, bits 7:6 select the instruction group, bits 5:3 select the operation and bits 2:0 name the register operand. The unit returns the shifted value, the outgoing carry and three condition flags. It also passes the decoded register index on to the register file, and marks the encodings that refer to a memory operand.

Operand fetch and write-back are handled outside the unit. One register stage holds every output. A result therefore appears one clock after its inputs were applied. The logical-zero flag reports whether the upper four bits of the result are all clear. It is not a parity indication.

Top module: `shrot_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted, every output is 0. This includes result, carry, the flags, register index, memory marker and illegal marker.
- R2: All outputs are registered. Inputs applied before a rising clock edge show at the outputs only after that edge, and the outputs do not change between edges.
- R3: With wide mode off, an opcode byte with bits 7:6 = 00 and bits 5:3 = 000 rotates left circularly: result = {a[6:0], a[7]}, carry = a[7]. Here a is operand bits 7:0.
- R4: Bits 5:3 = 001 rotates right circularly: result = {a[0], a[7:1]}, carry = a[0].
- R5: Bits 5:3 = 010 rotates left through carry: result = {a[6:0], cin}, carry = a[7].
- R6: Bits 5:3 = 011 rotates right through carry: result = {cin, a[7:1]}, carry = a[0].
- R7: Bits 5:3 = 100 shifts left and fills with zero: result = {a[6:0], 0}, carry = a[7].
- R8: Bits 5:3 = 101 shifts right arithmetically: result = {a[7], a[7:1]}, carry = a[0].
- R9: Bits 5:3 = 111 shifts right logically: result = {0, a[7:1]}, carry = a[0].
- R10: With wide mode on, the 16-bit operand x rotates right through carry: result = {cin, x[15:1]}, carry = x[0]. The operation bits of the opcode byte have no effect, and the illegal marker is 0.
- R11: The active width is 8 bits in narrow mode and 16 bits in wide mode. sign = the MSB of the result at that width. zero = 1 when the whole result is 0. logical-zero = 1 when the top four bits of the result are 0. In narrow mode, result bits 15:8 are 0, and operand bits 15:8 do not affect any output.
- R12: The register index output equals opcode bits 2:0 (0..5 = B,C,D,E,H,L; 7 = A). The memory-form output is 1 exactly when that field is 6, in both modes.
- R13: In narrow mode, an opcode with bits 7:6 ≠ 00 or bits 5:3 = 110 is illegal. For such an opcode the illegal marker is 1, result = a, carry = cin, and the flags are computed from that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| op_byte_i | input | 8 | Second opcode byte |
| wide_i | input | 1 | Selects the 16-bit rotate-right-through-carry form |
| operand_i | input | 16 | Operand; only bits 7:0 are used in narrow mode |
| carry_i | input | 1 | Incoming carry |
| result_o | output | 16 | Shifted or rotated value |
| carry_o | output | 1 | Outgoing carry |
| sign_o | output | 1 | MSB of the result at the active width |
| zero_o | output | 1 | Result is zero |
| lz_o | output | 1 | Top four bits of the result are zero |
| reg_sel_o | output | 3 | Register index from opcode bits 2:0 |
| mem_form_o | output | 1 | Register field selects a memory operand |
| illegal_o | output | 1 | Narrow-mode opcode is not a shift or rotate |

## Verification
Some properties are checked on every cycle:
- the wide-form carry and top-bit transfer;
- the clear upper byte in narrow mode;
- the consistency of the zero flag;
- the memory-form decode;
- the pass-through for illegal codes.

Only the bench's scenarios can show that each of the seven narrow operations moves the right bits. The same holds for the sign and logical-zero flags at both widths, and for operand bits 15:8 having no effect in narrow mode. These cases are covered by seeded random opcodes and operands, plus directed corners such as all-zero, all-one and top-bit-only values.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
    typedef enum logic [2:0] {
        OP_ROT_L_CIRC  = 3'd0,
        OP_ROT_R_CIRC  = 3'd1,
        OP_ROT_L_CARRY = 3'd2,
        OP_ROT_R_CARRY = 3'd3,
        OP_SHIFT_L     = 3'd4,
        OP_SHIFT_R_ARI = 3'd5,
        OP_PASS        = 3'd6,
        OP_SHIFT_R_LOG = 3'd7
    } shrot_op_e;

    localparam logic [1:0] GROUP_SHIFT = 2'b00;
    localparam logic [2:0] FIELD_MEM   = 3'd6;
endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int SEL_W = 3
) (
    input  logic [OPC_W-1:0] op_byte,
    output shrot_op_e        op,
    output logic [SEL_W-1:0] reg_sel,
    output logic             mem_form,
    output logic             illegal
);
    localparam int FLD_LO = SEL_W;
    localparam int GRP_LO = 2 * SEL_W;

    logic [1:0]       group;
    logic [SEL_W-1:0] field;

    always_comb begin
        group    = op_byte[GRP_LO +: 2];
        field    = op_byte[FLD_LO +: SEL_W];
        reg_sel  = op_byte[SEL_W-1:0];
        mem_form = (reg_sel == FIELD_MEM);
        illegal  = 1'b0;
        op       = OP_PASS;
        if (group != GROUP_SHIFT) begin
            illegal = 1'b1;
        end else begin
            case (field)
                3'd0:    op = OP_ROT_L_CIRC;
                3'd1:    op = OP_ROT_R_CIRC;
                3'd2:    op = OP_ROT_L_CARRY;
                3'd3:    op = OP_ROT_R_CARRY;
                3'd4:    op = OP_SHIFT_L;
                3'd5:    op = OP_SHIFT_R_ARI;
                3'd7:    op = OP_SHIFT_R_LOG;
                default: illegal = 1'b1;
            endcase
        end
    end

    always_comb begin
        a_pass_on_illegal_r13: assert (!illegal || op == OP_PASS);
    end
endmodule

// File: rtl/shrot_shift.sv
module shrot_shift
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  shrot_op_e    op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] y,
    output logic         cout
);
    always_comb begin
        y    = a;
        cout = cin;
        case (op)
            OP_ROT_L_CIRC: begin
                y    = {a[W-2:0], a[W-1]};
                cout = a[W-1];
            end
            OP_ROT_R_CIRC: begin
                y    = {a[0], a[W-1:1]};
                cout = a[0];
            end
            OP_ROT_L_CARRY: begin
                y    = {a[W-2:0], cin};
                cout = a[W-1];
            end
            OP_ROT_R_CARRY: begin
                y    = {cin, a[W-1:1]};
                cout = a[0];
            end
            OP_SHIFT_L: begin
                y    = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            OP_SHIFT_R_ARI: begin
                y    = {a[W-1], a[W-1:1]};
                cout = a[0];
            end
            OP_SHIFT_R_LOG: begin
                y    = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            default: begin
                y    = a;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
    parameter int W    = 8,
    parameter int LZ_W = 4
) (
    input  logic [W-1:0] y,
    output logic         sign,
    output logic         zero,
    output logic         lz
);
    always_comb begin
        sign = y[W-1];
        zero = ~|y;
        lz   = ~|y[W-1 -: LZ_W];
    end

    always_comb begin
        a_zero_implies_lz_r11: assert (!zero || lz);
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LZ_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   op_byte_i,
    input  logic                wide_i,
    input  logic [2*BYTE_W-1:0] operand_i,
    input  logic                carry_i,
    output logic [2*BYTE_W-1:0] result_o,
    output logic                carry_o,
    output logic                sign_o,
    output logic                zero_o,
    output logic                lz_o,
    output logic [2:0]          reg_sel_o,
    output logic                mem_form_o,
    output logic                illegal_o
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int SEL_W  = 3;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic              carry;
        logic              sign;
        logic              zero;
        logic              lz;
        logic [SEL_W-1:0]  reg_sel;
        logic              mem_form;
        logic              illegal;
    } out_s;

    shrot_op_e         dec_op;
    logic [SEL_W-1:0]  dec_sel;
    logic              dec_mem;
    logic              dec_ill;
    logic [BYTE_W-1:0] n_y;
    logic              n_c;
    logic [WORD_W-1:0] w_y;
    logic              w_c;
    logic              n_sign, n_zero, n_lz;
    logic              w_sign, w_zero, w_lz;
    out_s              out_d, out_q;

    shrot_decode #(.OPC_W(BYTE_W), .SEL_W(SEL_W)) u_decode (
        .op_byte  (op_byte_i),
        .op       (dec_op),
        .reg_sel  (dec_sel),
        .mem_form (dec_mem),
        .illegal  (dec_ill)
    );

    shrot_shift #(.W(BYTE_W)) u_shift_narrow (
        .op   (dec_op),
        .a    (operand_i[BYTE_W-1:0]),
        .cin  (carry_i),
        .y    (n_y),
        .cout (n_c)
    );

    shrot_shift #(.W(WORD_W)) u_shift_wide (
        .op   (OP_ROT_R_CARRY),
        .a    (operand_i),
        .cin  (carry_i),
        .y    (w_y),
        .cout (w_c)
    );

    shrot_flags #(.W(BYTE_W), .LZ_W(LZ_W)) u_flags_narrow (
        .y    (n_y),
        .sign (n_sign),
        .zero (n_zero),
        .lz   (n_lz)
    );

    shrot_flags #(.W(WORD_W), .LZ_W(LZ_W)) u_flags_wide (
        .y    (w_y),
        .sign (w_sign),
        .zero (w_zero),
        .lz   (w_lz)
    );

    always_comb begin
        out_d          = '0;
        out_d.reg_sel  = dec_sel;
        out_d.mem_form = dec_mem;
        if (wide_i) begin
            out_d.result  = w_y;
            out_d.carry   = w_c;
            out_d.sign    = w_sign;
            out_d.zero    = w_zero;
            out_d.lz      = w_lz;
            out_d.illegal = 1'b0;
        end else begin
            out_d.result  = {{BYTE_W{1'b0}}, n_y};
            out_d.carry   = n_c;
            out_d.sign    = n_sign;
            out_d.zero    = n_zero;
            out_d.lz      = n_lz;
            out_d.illegal = dec_ill;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o   = out_q.result;
    assign carry_o    = out_q.carry;
    assign sign_o     = out_q.sign;
    assign zero_o     = out_q.zero;
    assign lz_o       = out_q.lz;
    assign reg_sel_o  = out_q.reg_sel;
    assign mem_form_o = out_q.mem_form;
    assign illegal_o  = out_q.illegal;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !carry_o && !illegal_o && !zero_o));

    p_wide_rotate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wide_i)) |->
            (carry_o == $past(operand_i[0]) && result_o[WORD_W-1] == $past(carry_i)
             && !illegal_o));

    p_upper_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wide_i)) |-> (result_o[WORD_W-1:BYTE_W] == '0));

    p_zero_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (result_o == '0 && lz_o && !sign_o));

    p_mem_form_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mem_form_o == ($past(op_byte_i[SEL_W-1:0]) == FIELD_MEM)));

    p_illegal_pass_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (carry_o == $past(carry_i)
                       && result_o[BYTE_W-1:0] == $past(operand_i[BYTE_W-1:0])));
endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_byte_i = '0;
    logic        wide_i = 1'b0;
    logic [15:0] operand_i = '0;
    logic        carry_i = 1'b0;
    logic [15:0] result_o;
    logic        carry_o, sign_o, zero_o, lz_o, mem_form_o, illegal_o;
    logic [2:0]  reg_sel_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    shrot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_byte_i(op_byte_i), .wide_i(wide_i),
        .operand_i(operand_i), .carry_i(carry_i), .result_o(result_o),
        .carry_o(carry_o), .sign_o(sign_o), .zero_o(zero_o), .lz_o(lz_o),
        .reg_sel_o(reg_sel_o), .mem_form_o(mem_form_o), .illegal_o(illegal_o)
    );

    typedef struct packed {
        logic [15:0] r;
        logic        c, s, z, lz;
        logic [2:0]  sel;
        logic        mem, ill;
    } exp_s;

    function automatic exp_s model(input logic [7:0] ob, input logic w,
                                   input logic [15:0] x, input logic ci);
        exp_s e;
        logic [7:0] a;
        e = '0;
        a = x[7:0];
        if (w) begin
            e.r  = {ci, x[15:1]};
            e.c  = x[0];
            e.s  = e.r[15];
            e.z  = (e.r == 16'h0);
            e.lz = (e.r[15:12] == 4'h0);
        end else begin
            e.ill = (ob[7:6] != 2'b00) || (ob[5:3] == 3'd6);
            if (e.ill) begin
                e.r = {8'h00, a}; e.c = ci;
            end else begin
                case (ob[5:3])
                    3'd0: begin e.r = {8'h00, a[6:0], a[7]}; e.c = a[7]; end
                    3'd1: begin e.r = {8'h00, a[0], a[7:1]}; e.c = a[0]; end
                    3'd2: begin e.r = {8'h00, a[6:0], ci};   e.c = a[7]; end
                    3'd3: begin e.r = {8'h00, ci, a[7:1]};   e.c = a[0]; end
                    3'd4: begin e.r = {8'h00, a[6:0], 1'b0}; e.c = a[7]; end
                    3'd5: begin e.r = {8'h00, a[7], a[7:1]}; e.c = a[0]; end
                    default: begin e.r = {8'h00, 1'b0, a[7:1]}; e.c = a[0]; end
                endcase
            end
            e.s  = e.r[7];
            e.z  = (e.r[7:0] == 8'h00);
            e.lz = (e.r[7:4] == 4'h0);
        end
        e.sel = ob[2:0];
        e.mem = (ob[2:0] == 3'd6);
        return e;
    endfunction

    function automatic string op_tag(input logic [7:0] ob, input logic w);
        if (w) return "R10";
        if (ob[7:6] != 2'b00 || ob[5:3] == 3'd6) return "R13";
        case (ob[5:3])
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] ob, input logic w,
                           input logic [15:0] x, input logic ci);
        exp_s e;
        e = model(ob, w, x, ci);
        op_byte_i = ob; wide_i = w; operand_i = x; carry_i = ci;
        @(negedge clk);
        check(op_tag(ob, w), {15'h0, result_o, carry_o}, {15'h0, e.r, e.c});
        check("R11", {29'h0, sign_o, zero_o, lz_o}, {29'h0, e.s, e.z, e.lz});
        check("R12", {28'h0, reg_sel_o, mem_form_o}, {28'h0, e.sel, e.mem});
        if (!w) check("R13", {31'h0, illegal_o}, {31'h0, e.ill});
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [15:0] held;
        seed = 32'd1;
        void'($urandom(seed));
        op_byte_i = 8'h00; operand_i = 16'hFFFF; carry_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset held
        check("R1", {15'h0, result_o, carry_o}, 32'h0);
        check("R1", {24'h0, sign_o, zero_o, lz_o, reg_sel_o, mem_form_o, illegal_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3..R9 directed on a pattern
        for (int f = 0; f < 8; f++) run_one({2'b00, f[2:0], 3'd7}, 1'b0, 16'h00A5, 1'b1);
        for (int f = 0; f < 8; f++) run_one({2'b00, f[2:0], 3'd0}, 1'b0, 16'h0081, 1'b0);
        // R8: arithmetic keeps top bit; R11 sign
        run_one(8'h28, 1'b0, 16'h0080, 1'b0);
        // R11: zero, operand upper byte ignored in narrow mode
        run_one(8'h38, 1'b0, 16'hFF01, 1'b0);
        run_one(8'h20, 1'b0, 16'h5580, 1'b0);
        // R10: wide corners, opcode ignored
        run_one(8'hFF, 1'b1, 16'h0001, 1'b0);
        run_one(8'h06, 1'b1, 16'h0000, 1'b1);
        run_one(8'h43, 1'b1, 16'h1FFE, 1'b0);
        // R13: illegal codes pass through
        run_one(8'h31, 1'b0, 16'h003C, 1'b1);
        run_one(8'hC6, 1'b0, 16'h00F0, 1'b0);
        // R12: memory field
        run_one(8'h1E, 1'b0, 16'h0010, 1'b1);

        // R2: output holds between edges
        op_byte_i = 8'h00; wide_i = 1'b0; operand_i = 16'h0011; carry_i = 1'b0;
        @(negedge clk);
        held = result_o;
        op_byte_i = 8'h38; operand_i = 16'h00FE;
        #5;
        check("R2", {16'h0, result_o}, {16'h0, held});
        @(negedge clk);
        check("R2", {16'h0, result_o}, {16'h0, 16'h007F});

        // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  ob;
            logic        w;
            ob = 8'($urandom());
            if (($urandom() & 3) != 0) ob[7:6] = 2'b00;
            w = (($urandom() % 5) == 0);
            run_one(ob, w, 16'($urandom()), 1'($urandom()));
        end

        // R1: reset mid-run clears
        rst_n = 1'b0;
        #3;
        check("R1", {15'h0, result_o, carry_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule